// File: doc/BRIEF.md
# Clock Ratio Detector and Resync

This block sits in the system clock domain of an audio converter. It counts how many system clock cycles fall between consecutive rising edges of the left/right word clock. It then matches that count against the six system clock multiples the converter can use. Once the same multiple has been seen twice in a row, it reports a ratio code and a locked flag. It also owns the internal reset. An asynchronous power-on reset, or a low level on the external reset pin, holds the rest of the converter in initialization. When the pin returns high, a fixed count of system clock cycles must pass before operation resumes.

While locked, the block keeps a running sum of how far each word clock period falls from the nominal ratio. The unit of that sum is system clock cycles. The limit it is compared against is six bit clock periods, where a bit clock period is measured as the system clock cycles between bit clock rising edges. If the sum crosses the limit, if a period leaves the tolerance window, or if the word clock stops, lock is dropped. A force-zero request then tells the datapath to output bipolar zero until lock is regained.

Top module: `clk_ratio_det`

## Requirements
- R1: A word clock period that lies within ±2 system clock cycles of 128, 192, 256, 384, 512 or 768 maps to ratio code 0, 1, 2, 3, 4 or 5 respectively. ratio_o shows the code taken at lock and holds it while locked_o is high.
- R2: While rst_ni is low, init_rst_o and force_zero_o are high and locked_o is low. The external reset pin passes through one register. After release, init_rst_o stays high for 1024 further clock cycles counted from the first edge that registers the pin high. It is therefore low after the 1025th rising edge following release.
- R3: A low level on ext_rst_ni raises init_rst_o within two clock edges and clears lock. When the pin returns high, the same 1024-cycle count as in R2 runs before init_rst_o falls.
- R4: A word clock period more than 2 cycles away from every allowed ratio (for example 259 or 320) gives no lock, and it drops any lock that exists.
- R5: The first word clock rising edge after initialization only starts the measurement. locked_o rises after the second of two consecutive measured periods with the same code. The earliest case is the third rising edge, and the flag shows one clock after that edge has been registered.
- R6: While locked, the signed sum since lock of (measured period − nominal ratio) is tracked. When its magnitude would exceed 6 times the latest measured bit clock period, lock drops and force_zero_o rises.
- R7: Period jitter inside the ±2 window whose running sum stays within the R6 limit (alternating 258 and 254 at ratio 256) keeps lock and the ratio code.
- R8: A period matching a different ratio code drops lock. Relock needs two fresh consecutive matching periods, after which ratio_o shows the new code.
- R9: If no word clock rising edge arrives for more than 770 system clock cycles, lock drops.
- R10: force_zero_o is high whenever init_rst_o is high or locked_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ext_rst_ni | input | 1 | External reset pin, active low, sampled by clk_i |
| wclk_i | input | 1 | Word clock, synchronous to clk_i |
| bclk_i | input | 1 | Bit clock, synchronous to clk_i |
| ratio_o | output | 3 | Detected ratio code, 0..5 ascending |
| locked_o | output | 1 | Ratio lock flag |
| init_rst_o | output | 1 | Internal reset, high during initialization |
| force_zero_o | output | 1 | Request to force bipolar zero output |

## Verification
The bench targets the exact cycle of the first lock. A design that locks on a single good period, or that counts the first partial period, raises locked_o one word clock early. It measures the initialization length from both reset sources, so an off-by-one init counter is caught. It drives periods at the edges of the tolerance window, steady drift of one cycle per frame, and jitter that stays within the limit. A design with the wrong window or a drift sum that never resets would keep a bad lock or lose a good one. Ratio switches, a stopped word clock and a mid-run external reset check that lock falls and that force-zero follows it.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int NUM_RATIOS = 6;
  localparam int CODE_W     = 3;
  typedef logic [CODE_W-1:0] code_t;

  // ascending order; index is the ratio code
  function automatic int ratio_of(input int idx);
    case (idx)
      0:       ratio_of = 128;
      1:       ratio_of = 192;
      2:       ratio_of = 256;
      3:       ratio_of = 384;
      4:       ratio_of = 512;
      default: ratio_of = 768;
    endcase
  endfunction

  localparam int MAX_RATIO = 768;
endpackage

// File: rtl/crd_edge_sync.sv
module crd_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[0], sig_i};
  end

  assign rise_o = sh_q[0] & ~sh_q[1];
endmodule

// File: rtl/crd_init_seq.sv
module crd_init_seq #(
  parameter int INIT_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  output logic busy_o
);
  localparam int INIT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

  logic              ext_q;
  logic              busy_q;
  logic [INIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= 1'b0;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      ext_q <= ext_rst_ni;
      if (!ext_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == INIT_W'(INIT_CYCLES - 1)) busy_q <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/crd_period_meter.sv
module crd_period_meter #(
  parameter int CNT_W = 10,
  parameter int BCK_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wrise_i,
  input  logic             brise_i,
  output logic [CNT_W-1:0] per_o,
  output logic             seen_o,
  output logic [BCK_W-1:0] bper_o
);
  logic [CNT_W-1:0] per_q;
  logic [BCK_W-1:0] bcnt_q, bper_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      seen_q <= 1'b0;
      bcnt_q <= '0;
      bper_q <= '0;
    end else if (clr_i) begin
      per_q  <= '0;
      seen_q <= 1'b0;
      bcnt_q <= '0;
      bper_q <= '0;
    end else begin
      if (wrise_i) begin
        per_q  <= CNT_W'(1);
        seen_q <= 1'b1;
      end else if (per_q != '1) begin
        per_q <= per_q + 1'b1;
      end
      if (brise_i) begin
        bper_q <= bcnt_q;
        bcnt_q <= BCK_W'(1);
      end else if (bcnt_q != '1) begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assign per_o  = per_q;
  assign seen_o = seen_q;
  assign bper_o = bper_q;
endmodule

// File: rtl/crd_ratio_match.sv
module crd_ratio_match
  import crd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] per_i,
  output logic             hit_o,
  output code_t            code_o
);
  logic [NUM_RATIOS-1:0] hit_vec;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
    localparam logic [CNT_W-1:0] LO = CNT_W'(ratio_of(g) - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(ratio_of(g) + TOL);
    assign hit_vec[g] = (per_i >= LO) && (per_i <= HI);
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit_vec[i]) code_o = code_t'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/crd_lock_ctrl.sv
module crd_lock_ctrl
  import crd_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int BCK_W     = 6,
  parameter int ERR_W     = 16,
  parameter int TOL       = 2,
  parameter int DRIFT_BCK = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             frame_end_i,
  input  logic             seen_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [BCK_W-1:0] bper_i,
  input  logic             hit_i,
  input  code_t            code_i,
  output logic             locked_o,
  output code_t            ratio_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RATIO + TOL);

  logic                    locked_q, pok_q;
  code_t                   pcode_q, ratio_q;
  logic signed [ERR_W-1:0] err_q, err_nx, err_abs, nom;
  logic [ERR_W-1:0]        thr;
  logic                    timeout, drift_bad;

  assign nom       = ERR_W'(ratio_of(int'(ratio_q)));
  assign err_nx    = err_q + $signed(ERR_W'(per_i)) - nom;
  assign err_abs   = (err_nx < 0) ? -err_nx : err_nx;
  assign thr       = ERR_W'(bper_i) * ERR_W'(DRIFT_BCK);
  assign drift_bad = $unsigned(err_abs) > thr;
  assign timeout   = seen_i && (per_i > LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      pok_q    <= 1'b0;
      pcode_q  <= '0;
      ratio_q  <= '0;
      err_q    <= '0;
    end else if (clr_i) begin
      locked_q <= 1'b0;
      pok_q    <= 1'b0;
      pcode_q  <= '0;
      ratio_q  <= '0;
      err_q    <= '0;
    end else if (timeout) begin
      locked_q <= 1'b0;
      pok_q    <= 1'b0;
    end else if (frame_end_i) begin
      if (!hit_i) begin
        locked_q <= 1'b0;
        pok_q    <= 1'b0;
      end else if (locked_q) begin
        if ((code_i != ratio_q) || drift_bad) begin
          locked_q <= 1'b0;
          pok_q    <= 1'b0;
        end else begin
          err_q <= err_nx;
        end
      end else begin
        if (pok_q && (code_i == pcode_q)) begin
          locked_q <= 1'b1;
          ratio_q  <= code_i;
          err_q    <= '0;
        end
        pcode_q <= code_i;
        pok_q   <= 1'b1;
      end
    end
  end

  assign locked_o = locked_q;
  assign ratio_o  = ratio_q;
endmodule

// File: rtl/clk_ratio_det.sv
module clk_ratio_det
  import crd_pkg::*;
#(
  parameter int INIT_CYCLES = 1024,
  parameter int TOL         = 2,
  parameter int DRIFT_BCK   = 6,
  parameter int CNT_W       = 10,
  parameter int BCK_W       = 6,
  parameter int ERR_W       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_ni,
  input  logic              wclk_i,
  input  logic              bclk_i,
  output logic [CODE_W-1:0] ratio_o,
  output logic              locked_o,
  output logic              init_rst_o,
  output logic              force_zero_o
);
  logic             busy, wrise, brise, seen, hit;
  logic [CNT_W-1:0] per;
  logic [BCK_W-1:0] bper;
  code_t            code, ratio;
  logic             locked;

  crd_init_seq #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk_i, .rst_ni, .ext_rst_ni, .busy_o(busy)
  );

  crd_edge_sync u_wsync (.clk_i, .rst_ni, .sig_i(wclk_i), .rise_o(wrise));
  crd_edge_sync u_bsync (.clk_i, .rst_ni, .sig_i(bclk_i), .rise_o(brise));

  crd_period_meter #(.CNT_W(CNT_W), .BCK_W(BCK_W)) u_meter (
    .clk_i, .rst_ni, .clr_i(busy), .wrise_i(wrise), .brise_i(brise),
    .per_o(per), .seen_o(seen), .bper_o(bper)
  );

  crd_ratio_match #(.CNT_W(CNT_W), .TOL(TOL)) u_match (
    .per_i(per), .hit_o(hit), .code_o(code)
  );

  crd_lock_ctrl #(
    .CNT_W(CNT_W), .BCK_W(BCK_W), .ERR_W(ERR_W), .TOL(TOL), .DRIFT_BCK(DRIFT_BCK)
  ) u_lock (
    .clk_i, .rst_ni, .clr_i(busy), .frame_end_i(wrise & seen), .seen_i(seen),
    .per_i(per), .bper_i(bper), .hit_i(hit), .code_i(code),
    .locked_o(locked), .ratio_o(ratio)
  );

  assign ratio_o      = ratio;
  assign locked_o     = locked;
  assign init_rst_o   = busy;
  assign force_zero_o = busy | ~locked;
endmodule

// File: rtl/clk_ratio_det_chk.sv
module clk_ratio_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ext_rst_ni,
  input logic [2:0] ratio_o,
  input logic       locked_o,
  input logic       init_rst_o,
  input logic       force_zero_o
);
  // R1
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (ratio_o <= 3'd5));

  // R1
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> $stable(ratio_o));

  // R2
  init_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_rst_o |=> !locked_o);

  // R3
  pin_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |=> ##1 init_rst_o);

  // R10
  drop_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> force_zero_o);

  // R10
  init_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_rst_o |-> force_zero_o);
endmodule

bind clk_ratio_det clk_ratio_det_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .ratio_o(ratio_o),
  .locked_o(locked_o), .init_rst_o(init_rst_o), .force_zero_o(force_zero_o)
);

// File: tb/clk_ratio_det_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_det_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_rst_ni = 1'b1;
  logic       wclk_i = 1'b0;
  logic       bclk_i = 1'b0;
  logic [2:0] ratio_o;
  logic       locked_o, init_rst_o, force_zero_o;

  int n_chk = 0, n_bad = 0;
  bit chk_en = 0;
  int bdiv = 4, bph = 0;

  always #2 clk_i = ~clk_i;

  clk_ratio_det dut_i (
    .clk_i, .rst_ni, .ext_rst_ni, .wclk_i, .bclk_i,
    .ratio_o, .locked_o, .init_rst_o, .force_zero_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int  ratios[6] = '{128, 192, 256, 384, 512, 768};
  bit  m_ext, m_busy, m_lr1, m_lr2, m_bk1, m_bk2, m_seen, m_locked, m_pok;
  int  m_icnt, m_per, m_bcnt, m_bper, m_pcode, m_ratio, m_err;
  bit  t_lrr, t_bkr;
  int  t_code, t_err;

  function automatic int classify(input int p);
    classify = -1;
    foreach (ratios[i]) if (p >= ratios[i] - 2 && p <= ratios[i] + 2) classify = i;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ext = 0; m_busy = 1; m_icnt = 0; m_lr1 = 0; m_lr2 = 0; m_bk1 = 0; m_bk2 = 0;
      m_per = 0; m_seen = 0; m_bcnt = 0; m_bper = 0; m_locked = 0; m_pok = 0;
      m_pcode = 0; m_ratio = 0; m_err = 0;
    end else begin
      t_lrr = m_lr1 && !m_lr2;
      t_bkr = m_bk1 && !m_bk2;
      if (m_busy) begin
        m_locked = 0; m_pok = 0; m_pcode = 0; m_ratio = 0; m_err = 0;
      end else if (m_seen && m_per > 770) begin
        m_locked = 0; m_pok = 0;
      end else if (t_lrr && m_seen) begin
        t_code = classify(m_per);
        if (t_code < 0) begin
          m_locked = 0; m_pok = 0;
        end else if (m_locked) begin
          t_err = m_err + m_per - ratios[m_ratio];
          if (t_code != m_ratio || (t_err < 0 ? -t_err : t_err) > 6 * m_bper) begin
            m_locked = 0; m_pok = 0;
          end else m_err = t_err;
        end else begin
          if (m_pok && t_code == m_pcode) begin
            m_locked = 1; m_ratio = t_code; m_err = 0;
          end
          m_pcode = t_code; m_pok = 1;
        end
      end
      if (m_busy) begin
        m_per = 0; m_seen = 0; m_bcnt = 0; m_bper = 0;
      end else begin
        if (t_lrr) begin m_per = 1; m_seen = 1; end
        else if (m_per < 1023) m_per++;
        if (t_bkr) begin m_bper = m_bcnt; m_bcnt = 1; end
        else if (m_bcnt < 63) m_bcnt++;
      end
      if (!m_ext) begin m_icnt = 0; m_busy = 1; end
      else if (m_busy) begin
        if (m_icnt == 1023) m_busy = 0;
        m_icnt++;
      end
      m_ext = ext_rst_ni;
      m_lr2 = m_lr1; m_lr1 = wclk_i;
      m_bk2 = m_bk1; m_bk1 = bclk_i;
    end
  end

  always @(negedge clk_i) begin
    if (chk_en) begin
      chk("R5 locked", int'(locked_o), int'(m_locked));
      chk("R1 ratio", int'(ratio_o), m_ratio);
      chk("R2 init", int'(init_rst_o), int'(m_busy));
      chk("R10 force", int'(force_zero_o), int'(m_busy || !m_locked));
    end
  end

  // stimulus: one negedge step with free-running bit clock
  task automatic step(input bit w);
    @(negedge clk_i);
    wclk_i = w;
    bclk_i = (bph < bdiv / 2);
    bph = (bph + 1) % bdiv;
  endtask

  task automatic frame(input int per);
    for (int k = 0; k < per; k++) step(k < per / 2);
  endtask

  task automatic frames(input int per, input int n);
    for (int i = 0; i < n; i++) frame(per);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic count_init(input string tag);
    int n = 0;
    @(negedge clk_i);
    while (init_rst_o && n < 5000) begin
      n++;
      @(negedge clk_i);
    end
    chk(tag, n, 1024);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit saw;
    int nfr;
    repeat (3) @(negedge clk_i);
    chk_en = 1;
    // R2 reset state
    chk("R2 reset init", int'(init_rst_o), 1);
    chk("R2 reset locked", int'(locked_o), 0);
    chk("R10 reset force", int'(force_zero_o), 1);
    rst_ni = 1'b1;
    count_init("R2 init length");

    // R5 lock latency at 256
    bdiv = 4;
    frames(256, 2);
    chk("R5 no early lock", int'(locked_o), 0);
    frame(256);
    chk("R5 lock third edge", int'(locked_o), 1);
    chk("R1 code 256", int'(ratio_o), 2);

    // R8 switch to 128, R1 codes
    bdiv = 2;
    frames(128, 2);
    chk("R8 unlock on change", int'(locked_o), 0);
    frames(128, 2);
    chk("R8 relock", int'(locked_o), 1);
    chk("R1 code 128", int'(ratio_o), 0);
    bdiv = 3;  frames(192, 4); chk("R1 code 192", int'(ratio_o), 1);
    bdiv = 6;  frames(384, 4); chk("R1 code 384", int'(ratio_o), 3);
    bdiv = 8;  frames(512, 4); chk("R1 code 512", int'(ratio_o), 4);
    bdiv = 12; frames(768, 4); chk("R1 code 768", int'(ratio_o), 5);
    chk("R1 locked 768", int'(locked_o), 1);

    // R7 jitter inside window
    bdiv = 4;
    frames(256, 4);
    saw = 0;
    for (int i = 0; i < 10; i++) begin
      frame(258); saw |= !locked_o;
      frame(254); saw |= !locked_o;
    end
    chk("R7 jitter keeps lock", int'(saw), 0);
    chk("R7 code kept", int'(ratio_o), 2);

    // R4 out of window
    frames(259, 5);
    chk("R4 259 no lock", int'(locked_o), 0);
    frames(320, 5);
    chk("R4 320 no lock", int'(locked_o), 0);

    // R6 steady drift
    frames(256, 4);
    chk("R6 locked before drift", int'(locked_o), 1);
    saw = 0; nfr = 0;
    for (int i = 0; i < 32; i++) begin
      frame(257);
      if (!saw && !locked_o) begin saw = 1; nfr = i; end
    end
    chk("R6 drift unlock", int'(saw), 1);
    chk("R6 not before limit", int'(nfr >= 20), 1);

    // R9 word clock stops
    frames(256, 4);
    idle(500);
    chk("R9 still locked", int'(locked_o), 1);
    idle(300);
    chk("R9 timeout unlock", int'(locked_o), 0);
    chk("R10 force after timeout", int'(force_zero_o), 1);

    // R3 external reset
    frames(256, 4);
    chk("R3 locked before pin", int'(locked_o), 1);
    ext_rst_ni = 1'b0;
    idle(10);
    chk("R3 init high", int'(init_rst_o), 1);
    chk("R3 lock cleared", int'(locked_o), 0);
    ext_rst_ni = 1'b1;
    count_init("R3 init length");
    frames(256, 3);
    chk("R3 relock after init", int'(locked_o), 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule